// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts hardware events and clock cycles for profiling. It holds one cycle counter and four 32-bit event counters. Each event counter has an 8-bit selector that picks one line from a bank of single-cycle event strobes, and the counter advances on every cycle in which that line is high. Software reaches the unit through a simple register port: a write strobe, an address and write data. Read data is combinational from the address.

Sampling works by preloading a counter with the two's complement of a period N. The counter then wraps after N counted events. A wrap sets a sticky overflow flag. The flags are masked by an interrupt enable register and ORed into one registered interrupt line. Software clears flags by writing ones. It reloads the counter and carries on.

The cycle counter runs from a small mode machine with four named states. `CC_HALT` means stopped with divide off, and `CC_HALT_DIV` means stopped with divide on. `CC_FULL` counts every clock. `CC_SLOW` counts once per 64 clocks.
The only transitions are control-register writes, and they are named by the written bits:
- bit0=0, bit3=0 leads to `CC_HALT`;
- bit0=0, bit3=1 leads to `CC_HALT_DIV`;
- bit0=1, bit3=0 leads to `CC_FULL`;
- bit0=1, bit3=1 leads to `CC_SLOW`.

Any other cycle stays in the current state. In `CC_SLOW` a 6-bit prescaler sets the phase. In every other state the prescaler is held at zero.

Top module: `pmu_evmon`

## Requirements
- R1: When the run bit (control bit 0) is clear, neither the cycle counter nor any event counter advances.
- R2: A control write with bit 1 set zeroes all four event counters, and one with bit 2 set zeroes the cycle counter. Neither bit is stored, and both read as 0.
- R3: With run set and control bit 3 set, the cycle counter advances once per 64 clocks. The first advance comes 64 edges after the write that enters this mode. A write to the cycle counter or a cycle reset restarts that 64-clock phase.
- R4: The control register is at address 0. Bits 0 (run) and 3 (divide) are stored. Bits 31:24 always read the fixed identifier 0xA5, and writes to them are ignored. Bits 4 to 23 read 0. Checks compare reads masked with 0xFF000009.
- R5: The event select register at address 3 holds four 8-bit codes: counter 0 in bits 7:0, counter 1 in 15:8, counter 2 in 23:16 and counter 3 in 31:24. A counter whose code is c advances by one on each running cycle in which event strobe c is high.
- R6: Code 0xFF disables a counter, and so does any code not below the number of event inputs (16 by default). Such a counter never advances.
- R7: The overflow flag register is at address 2. Bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. A wrap from 0xFFFFFFFF to 0 sets the flag on that same edge. The counter goes on from 0, and the flag stays set until it is cleared.
- R8: Writing a 1 to a flag bit clears it, and a 0 leaves it. If a wrap and a clear meet on the same edge, the flag ends up set.
- R9: The cycle counter is at address 4 and event counters 0 to 3 are at addresses 5 to 8. All are writable. After loading 0xFFFFFFFF-N+1, the counter reads 0 and its flag is set after exactly N counted events.
- R10: The interrupt enable register is at address 1 and has the flag layout. The interrupt output is set on the edge after an enabled flag is set. It is cleared on the edge after no enabled flag remains.
- R11: A software write to a counter takes priority over a reset bit or an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_strobe | input | NUM_EV | Single-cycle event pulses |
| irq_o | output | 1 | Registered overflow interrupt |

## Verification
A register read is due in the same cycle as its address, because read data is combinational. A write or a counted event shows on the read port after the rising edge that commits it. The interrupt follows one edge after the flag it reflects, and the slowed cycle counter first moves 64 edges after the mode write. The bench changes inputs just after each rising edge, and it updates its model on the rising edge from the inputs in force. At every falling edge it compares the read port and the interrupt line against the model. Directed reads are placed at the exact falling edge those latencies predict.

// File: rtl/pmu_evmon_pkg.sv
package pmu_evmon_pkg;
    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int NUM_CNT = 4;

    localparam logic [AW-1:0] ADDR_CTRL  = 4'd0;
    localparam logic [AW-1:0] ADDR_IRQEN = 4'd1;
    localparam logic [AW-1:0] ADDR_FLAGS = 4'd2;
    localparam logic [AW-1:0] ADDR_EVSEL = 4'd3;
    localparam logic [AW-1:0] ADDR_CYC   = 4'd4;
    localparam logic [AW-1:0] ADDR_EV0   = 4'd5;

    localparam int CB_RUN   = 0;
    localparam int CB_EVCLR = 1;
    localparam int CB_CYCLR = 2;
    localparam int CB_DIV   = 3;

    localparam logic [7:0] CODE_OFF = 8'hFF;

    typedef enum logic [1:0] {
        CC_HALT,
        CC_HALT_DIV,
        CC_FULL,
        CC_SLOW
    } cc_state_e;
endpackage

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter
    import pmu_evmon_pkg::*;
#(
    parameter int PRESCALE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic          mode_run_i,
    input  logic          mode_div_i,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          run_o,
    output logic          div_o,
    output logic [DW-1:0] cnt_o,
    output logic          wrap_o
);
    localparam int            PW       = $clog2(PRESCALE);
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    cc_state_e     state_q, state_d;
    logic [PW-1:0] pre_q;
    logic [DW-1:0] cnt_q;
    logic          advance;

    always_comb begin
        state_d = state_q;
        if (mode_wr_i) begin
            unique case ({mode_run_i, mode_div_i})
                2'b00: state_d = CC_HALT;
                2'b01: state_d = CC_HALT_DIV;
                2'b10: state_d = CC_FULL;
                2'b11: state_d = CC_SLOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CC_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CC_HALT:     begin run_o = 1'b0; div_o = 1'b0; advance = 1'b0; end
            CC_HALT_DIV: begin run_o = 1'b0; div_o = 1'b1; advance = 1'b0; end
            CC_FULL:     begin run_o = 1'b1; div_o = 1'b0; advance = 1'b1; end
            CC_SLOW:     begin run_o = 1'b1; div_o = 1'b1; advance = (pre_q == PRE_LAST); end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (state_q != CC_SLOW || clr_i || wr_i || pre_q == PRE_LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (wr_i)    cnt_q <= wdata_i;
        else if (clr_i)   cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = advance && !wr_i && !clr_i && (&cnt_q);
    assign cnt_o  = cnt_q;

    // R3
    slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CC_SLOW && !wr_i && !clr_i && pre_q != PRE_LAST) |=> (cnt_q == $past(cnt_q)));

    // R1
    cyc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !wr_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pmu_ev_counter.sv
module pmu_ev_counter
    import pmu_evmon_pkg::*;
#(
    parameter int NUM_EV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [7:0]        code_i,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     cnt_o,
    output logic              wrap_o
);
    localparam int IW = $clog2(NUM_EV);

    logic [DW-1:0] cnt_q;
    logic          hit;

    assign hit = run_i && (code_i != CODE_OFF) && (int'(code_i) < NUM_EV)
                 && ev_i[code_i[IW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_i)  cnt_q <= wdata_i;
        else if (clr_i) cnt_q <= '0;
        else if (hit)   cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = hit && !wr_i && !clr_i && (&cnt_q);
    assign cnt_o  = cnt_q;

    // R6
    code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == CODE_OFF && !wr_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

    // R1
    ev_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pmu_evmon.sv
module pmu_evmon
    import pmu_evmon_pkg::*;
#(
    parameter int         NUM_EV   = 16,
    parameter int         PRESCALE = 64,
    parameter logic [7:0] CTRL_ID  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_EV-1:0] ev_strobe,
    output logic              irq_o
);
    localparam int NFLAG = NUM_CNT + 1;

    logic [NFLAG-1:0] flags_q, ie_q, wraps, clr_mask;
    logic [DW-1:0]    evsel_q;
    logic             irq_q;
    logic             wr_ctrl, clr_ev, clr_cyc, run, div;
    logic [DW-1:0]    cyc_cnt;
    logic [DW-1:0]    ev_cnt [NUM_CNT];

    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign clr_ev  = wr_ctrl && bus_wdata[CB_EVCLR];
    assign clr_cyc = wr_ctrl && bus_wdata[CB_CYCLR];

    pmu_cyc_counter #(.PRESCALE(PRESCALE)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr_i (wr_ctrl),
        .mode_run_i(bus_wdata[CB_RUN]),
        .mode_div_i(bus_wdata[CB_DIV]),
        .clr_i     (clr_cyc),
        .wr_i      (bus_wr && bus_addr == ADDR_CYC),
        .wdata_i   (bus_wdata),
        .run_o     (run),
        .div_o     (div),
        .cnt_o     (cyc_cnt),
        .wrap_o    (wraps[0])
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_ev
        pmu_ev_counter #(.NUM_EV(NUM_EV)) u_ev (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run),
            .code_i (evsel_q[8*k +: 8]),
            .ev_i   (ev_strobe),
            .clr_i  (clr_ev),
            .wr_i   (bus_wr && bus_addr == AW'(int'(ADDR_EV0) + k)),
            .wdata_i(bus_wdata),
            .cnt_o  (ev_cnt[k]),
            .wrap_o (wraps[k+1])
        );
    end

    assign clr_mask = (bus_wr && bus_addr == ADDR_FLAGS) ? bus_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            ie_q    <= '0;
            evsel_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | wraps;
            irq_q   <= |(flags_q & ie_q);
            if (bus_wr && bus_addr == ADDR_IRQEN) ie_q    <= bus_wdata[NFLAG-1:0];
            if (bus_wr && bus_addr == ADDR_EVSEL) evsel_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = {CTRL_ID, 20'b0, div, 2'b00, run};
            ADDR_IRQEN: bus_rdata = DW'(ie_q);
            ADDR_FLAGS: bus_rdata = DW'(flags_q);
            ADDR_EVSEL: bus_rdata = evsel_q;
            ADDR_CYC:   bus_rdata = cyc_cnt;
            default: begin
                for (int k = 0; k < NUM_CNT; k++)
                    if (bus_addr == AW'(int'(ADDR_EV0) + k)) bus_rdata = ev_cnt[k];
            end
        endcase
    end

    assign irq_o = irq_q;

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wraps) |=> ((flags_q & $past(wraps)) == $past(wraps)));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_q & ie_q)) |=> irq_o);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags_q & ie_q)) |=> !irq_o);
endmodule

// File: tb/pmu_evmon_bench.sv
module pmu_evmon_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         NEV        = 16;
    localparam logic [7:0] ID         = 8'hA5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NEV-1:0]  ev_strobe = '0;
    logic            irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pmu_evmon #(.NUM_EV(NEV), .PRESCALE(64), .CTRL_ID(ID)) u_pmu_evmon (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_strobe(ev_strobe), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [31:0] m_cnt [5];
    bit [4:0]  m_flags, m_ie;
    bit [31:0] m_sel;
    bit        m_en, m_div, m_irq;
    int        m_pre;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_flags = 0; m_ie = 0; m_sel = 0; m_en = 0; m_div = 0; m_irq = 0; m_pre = 0;
        end else begin
            bit [4:0] wrap;
            bit wctl, clr_e, clr_c, adv;
            wrap  = 0;
            wctl  = bus_wr && bus_addr == 0;
            clr_e = wctl && bus_wdata[1];
            clr_c = wctl && bus_wdata[2];
            adv   = m_en && (!m_div || m_pre == 63);
            if (bus_wr && bus_addr == 4) m_cnt[0] = bus_wdata;
            else if (clr_c) m_cnt[0] = 0;
            else if (adv) begin
                if (m_cnt[0] == 32'hFFFF_FFFF) wrap[0] = 1;
                m_cnt[0] = m_cnt[0] + 1;
            end
            if (!(m_en && m_div) || clr_c || (bus_wr && bus_addr == 4) || m_pre == 63) m_pre = 0;
            else m_pre = m_pre + 1;
            for (int k = 0; k < 4; k++) begin
                int code;
                bit hit;
                code = int'(m_sel[8*k +: 8]);
                hit  = m_en && code != 255 && code < NEV && ev_strobe[code % NEV];
                if (bus_wr && int'(bus_addr) == 5 + k) m_cnt[k+1] = bus_wdata;
                else if (clr_e) m_cnt[k+1] = 0;
                else if (hit) begin
                    if (m_cnt[k+1] == 32'hFFFF_FFFF) wrap[k+1] = 1;
                    m_cnt[k+1] = m_cnt[k+1] + 1;
                end
            end
            m_irq = |(m_flags & m_ie);
            if (bus_wr && bus_addr == 2) m_flags = m_flags & ~bus_wdata[4:0];
            m_flags = m_flags | wrap;
            if (wctl) begin m_en = bus_wdata[0]; m_div = bus_wdata[3]; end
            if (bus_wr && bus_addr == 1) m_ie = bus_wdata[4:0];
            if (bus_wr && bus_addr == 3) m_sel = bus_wdata;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            0: return {ID, 20'b0, m_div, 2'b00, m_en};
            1: return {27'b0, m_ie};
            2: return {27'b0, m_flags};
            3: return m_sel;
            4, 5, 6, 7, 8: return m_cnt[int'(a) - 4];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            0: return "R4";
            1: return "R10";
            2: return "R7";
            3: return "R5";
            4: return "R3";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bus_addr == 0) chk("R4", bus_rdata & 32'hFF00_0009, exp_rd(0) & 32'hFF00_0009);
            else               chk(req_of(bus_addr), bus_rdata, exp_rd(bus_addr));
            chk("R10", {31'b0, irq_o}, {31'b0, m_irq});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [NEV-1:0] ev = '0);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ev_strobe = ev;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a; ev_strobe = '0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic strobe(input logic [NEV-1:0] ev);
        @(posedge clk); #1;
        bus_wr = 1'b0; ev_strobe = ev;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            bus_wr = 1'b0; ev_strobe = '0;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, c1, c2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state, control identifier (R4)
        rd(0, v); chk("R4 reset ctrl", v & 32'hFF00_0009, 32'hA500_0000);
        for (int a = 1; a <= 8; a++) begin
            rd(4'(a), v); chk("R9 reset value", v, 32'h0);
        end
        wr(0, 32'hFFFF_FFF6);
        rd(0, v); chk("R4 upper bits ignored", v & 32'hFF00_0009, 32'hA500_0000);

        // routing, preload, disabled codes (R5 R6 R9 R7)
        wr(3, {8'hFF, 8'h20, 8'h0B, 8'h00});
        wr(0, 32'h1);
        wr(5, 32'hFFFF_FFFB);
        repeat (5) strobe(16'h0801);
        rd(5, v); chk("R9 preload wraps to zero", v, 32'h0);
        rd(6, v); chk("R5 counter1 code 0x0B", v, 32'd5);
        rd(7, v); chk("R6 out of range code", v, 32'h0);
        rd(8, v); chk("R6 code 0xFF", v, 32'h0);
        rd(2, v); chk("R7 flag bit1", v, 32'h2);

        // interrupt timing (R10)
        wr(1, 32'h2);
        rd(2, v); chk("R10 irq not yet", {31'b0, irq_o}, 32'h0);
        rd(2, v); chk("R10 irq raised", {31'b0, irq_o}, 32'h1);

        // write-one-to-clear (R8) and fall timing (R10)
        wr(2, 32'h2);
        rd(2, v); chk("R8 cleared", v, 32'h0);
        chk("R10 irq held one edge", {31'b0, irq_o}, 32'h1);
        rd(2, v); chk("R10 irq dropped", {31'b0, irq_o}, 32'h0);

        // wrap continues, sticky flag (R7)
        wr(6, 32'hFFFF_FFFF);
        strobe(16'h0800);
        rd(6, v); chk("R7 wrap to zero", v, 32'h0);
        strobe(16'h0800);
        rd(6, v); chk("R7 keeps counting", v, 32'h1);
        rd(2, v); chk("R7 sticky flag", v & 32'h4, 32'h4);

        // set beats clear on the same edge (R8)
        wr(5, 32'hFFFF_FFFF);
        wr(2, 32'h1F, 16'h0001);
        rd(2, v); chk("R8 set wins", v & 32'h6, 32'h2);

        // write beats increment (R11)
        wr(5, 32'd100, 16'h0001);
        rd(5, v); chk("R11 write priority", v, 32'd100);

        // reset bits (R2)
        wr(0, 32'h3);
        rd(6, v); chk("R2 event reset", v, 32'h0);
        rd(5, v); chk("R2 event reset", v, 32'h0);
        rd(4, v); chk("R2 cycle kept", {31'b0, v != 0}, 32'h1);
        wr(0, 32'h5);
        rd(4, v); chk("R2 cycle reset", v, 32'h0);
        rd(4, v); chk("R2 cycle restarts", v, 32'h1);
        rd(0, v); chk("R2 reset bits read zero", v & 32'h6, 32'h0);

        // disabled: nothing counts (R1)
        wr(0, 32'h0);
        repeat (3) strobe(16'h0801);
        rd(5, v); chk("R1 event halted", v, 32'h0);
        rd(4, c1);
        rd(4, c2); chk("R1 cycle halted", c2, c1);

        // divide by 64 (R3)
        wr(0, 32'hD);
        rd(4, v); chk("R3 start", v, 32'h0);
        idle(62);
        rd(4, v); chk("R3 edge 63", v, 32'h0);
        rd(4, v); chk("R3 edge 64", v, 32'h1);
        rd(0, v); chk("R4 divide bit", v & 32'hFF00_0009, 32'hA500_0009);

        // cycle counter wrap sets bit0 (R7 R9)
        wr(2, 32'h1F);
        wr(0, 32'h1);
        wr(4, 32'hFFFF_FFFE);
        rd(4, v); chk("R9 cycle write", v, 32'hFFFF_FFFE);
        rd(4, v);
        rd(2, v); chk("R7 cycle flag bit0", v & 32'h1, 32'h1);

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            bus_wr    = ($urandom % 6) == 0;
            bus_addr  = 4'($urandom % 9);
            bus_wdata = $urandom;
            if (bus_addr == 0) bus_wdata[0] = 1'b1;
            if (bus_addr == 3) bus_wdata = $urandom & 32'h0F0F_0F0F;
            ev_strobe = NEV'($urandom);
        end
        idle(2);
        finish_run();
    end
endmodule